// File: doc/BRIEF.md
# Latched-Address Synchronous One-Time-Programmable ROM

This block models a 512-word by 8-bit one-time-programmable read-only memory with a synchronous read. An active-low chip enable is sampled on the system clock. When chip enable is seen going low, the block registers the read address and turns on the row and column decoders. When chip enable is seen going high again, the addressed word is loaded into an output data register. That register then holds its value until the next read completes. The address bus is free to change between the two edges, so a multiplexed address/data bus can share the pins.

The storage is 64 rows of 64 fuse bits. The upper six address bits pick a row. The lower three address bits pick one of eight 8-bit column groups within that row. Every fuse starts at 0. A program port can blow a single fuse to 1, and nothing can return a fuse to 0.

Three output-enable inputs gate the output: two are active low and one is active high. The undriven state is represented by a low valid flag and an all-zero data bus. Output enable acts independently of chip enable and of the read sequence.

Top module: `otp_rom_sync`

## Requirements
- R1: While `rst_n` is low at a clock edge, every fuse is cleared to 0 and the output data register is cleared to 0. After reset, `data_out` reads 0x00 whenever the output is enabled, until a read completes.
- R2: A chip-enable falling edge is detected when `ce_n` is sampled low at a clock edge after being sampled high at the previous edge. At that edge, `addr` is registered. Any later change of `addr` has no effect on the word captured by the following rising edge.
- R3: A chip-enable rising edge is detected when `ce_n` is sampled high after being sampled low. At that edge, the output data register loads the addressed word. It then holds that word while `ce_n` stays high, even if the fuse array is programmed in the meantime.
- R4: A fuse that has never been programmed reads as 0.
- R5: A clock edge with `prog_en` high sets bit `prog_bit` (0 = least significant bit of the word) of the word at `prog_addr` to 1. The change is visible to any read that completes afterwards.
- R6: Programming never clears a fuse. Programming an already-set bit leaves the word unchanged, and every bit not selected keeps its value.
- R7: `out_valid` is 1 in the same cycle exactly when `oe_n_a` = 0, `oe_n_b` = 0 and `oe_hi` = 1.
- R8: While `out_valid` is 0, `data_out` is 0x00. While `out_valid` is 1, `data_out` shows the output data register.
- R9: Output enable is independent of chip enable. A read that completes while the output is disabled still loads the word, and the word appears once the enables become active.
- R10: Address bits [8:3] select the row and bits [2:0] select the 8-bit column group. Words in different rows or different column groups are independent. The decoder selects exactly one row from a falling edge until the next rising edge, and no row at other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (returns the array to the blank state) |
| ce_n | input | 1 | Active-low chip enable; the falling edge registers the address, the rising edge loads the word |
| addr | input | 9 | Read address |
| oe_n_a | input | 1 | First active-low output enable |
| oe_n_b | input | 1 | Second active-low output enable |
| oe_hi | input | 1 | Active-high output enable |
| prog_en | input | 1 | Program strobe; sets one fuse per clock edge while high |
| prog_addr | input | 9 | Word address to program |
| prog_bit | input | 3 | Bit index within the word to set |
| data_out | output | 8 | Read word, zero while not enabled |
| out_valid | output | 1 | High when the output is driven |

## Verification
The assertions assume that `ce_n` and `addr` are stable at each sampling clock edge. They also assume that `rst_n` is low at the first edge, so that the registered chip enable and the fuse state are defined before any property is evaluated. The stimulus changes every input only on the falling clock edge. It holds reset for several cycles at the start, so each property sees defined values from its first enabled cycle. Programming and read edges are never placed on the same clock edge, so the expected word of each read is unambiguous.

// File: rtl/otp_pkg.sv
// Package otp_pkg
// Shared types for the synchronous one-time-programmable ROM.
// Assumes chip enable is sampled once per clock by the edge detector.
package otp_pkg;

    // Event decoded from two successive samples of the active-low chip enable
    typedef enum logic [1:0] {
        CE_IDLE = 2'd0,
        CE_FALL = 2'd1,
        CE_RISE = 2'd2
    } ce_evt_t;

endpackage

// File: rtl/otp_edge_latch.sv
// Module otp_edge_latch
// Samples the active-low chip enable, decodes its falling and rising edges,
// registers the read address on the falling edge, and keeps the decoder
// enable high from the falling edge until the rising edge.
// Assumes ce_n and addr_in are synchronous to clk.
module otp_edge_latch
    import otp_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr_in,
    output ce_evt_t           evt,
    output logic              ce_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              dec_en
);

    // Classify the current sample against the previous one
    always_comb begin
        if (ce_q && !ce_n) begin
            evt = CE_FALL;
        end else if (!ce_q && ce_n) begin
            evt = CE_RISE;
        end else begin
            evt = CE_IDLE;
        end
    end

    // Track the enable, capture the address, and gate the decoders
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q   <= 1'b1;
            addr_q <= '0;
            dec_en <= 1'b0;
        end else begin
            ce_q <= ce_n;
            if (evt == CE_FALL) begin
                addr_q <= addr_in;
                dec_en <= 1'b1;
            end else if (evt == CE_RISE) begin
                dec_en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/otp_fuse_array.sv
// Module otp_fuse_array
// Fuse storage of ROWS rows by COLS bits with a gated row decoder and a
// column-group multiplexer. The program port can only set bits to 1.
// Assumes DATA_W is a power of two, so {column, bit} forms the column index.
module otp_fuse_array #(
    parameter int ROW_BITS = 6,
    parameter int COL_BITS = 3,
    parameter int DATA_W   = 8,
    parameter int BIT_W    = 3
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            prog_en,
    input  logic [ROW_BITS+COL_BITS-1:0]                    prog_addr,
    input  logic [BIT_W-1:0]                                prog_bit,
    input  logic                                            dec_en,
    input  logic [ROW_BITS+COL_BITS-1:0]                    rd_addr,
    output logic [DATA_W-1:0]                               rd_word,
    output logic [(1<<ROW_BITS)-1:0]                        row_sel,
    output logic [(1<<ROW_BITS)*(DATA_W<<COL_BITS)-1:0]     fuse_flat
);

    localparam int ROWS   = 1 << ROW_BITS;
    localparam int COLS   = DATA_W << COL_BITS;
    localparam int ADDR_W = ROW_BITS + COL_BITS;

    logic [COLS-1:0]     fuse_q [ROWS];
    logic [ROW_BITS-1:0] p_row;
    logic [COL_BITS-1:0] p_col;
    logic [COL_BITS-1:0] r_col;
    logic [COLS-1:0]     row_word;

    assign p_row = prog_addr[ADDR_W-1:COL_BITS];
    assign p_col = prog_addr[COL_BITS-1:0];
    assign r_col = rd_addr[COL_BITS-1:0];

    // Blank the array on reset; otherwise blow one selected fuse per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                fuse_q[r] <= '0;
            end
        end else if (prog_en) begin
            fuse_q[p_row][{p_col, prog_bit}] <= 1'b1;
        end
    end

    // One-hot row decode, enabled only between the falling and rising edges
    always_comb begin
        row_sel = '0;
        if (dec_en) begin
            row_sel[rd_addr[ADDR_W-1:COL_BITS]] = 1'b1;
        end
    end

    // Merge the selected row onto the shared column lines
    always_comb begin
        row_word = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_sel[r]) begin
                row_word = row_word | fuse_q[r];
            end
        end
    end

    // Pick the addressed 8-bit column group
    assign rd_word = row_word[r_col*DATA_W +: DATA_W];

    // Flatten the rows for observation
    for (genvar g = 0; g < ROWS; g++) begin : g_flat
        assign fuse_flat[g*COLS +: COLS] = fuse_q[g];
    end

endmodule

// File: rtl/otp_out_stage.sv
// Module otp_out_stage
// Output data register, loaded on the chip-enable rising edge and held
// otherwise, followed by the three-input output gate. The undriven state is
// shown as out_valid low with an all-zero bus.
// Assumes evt comes from otp_edge_latch in the same clock domain.
module otp_out_stage
    import otp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ce_evt_t           evt,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              oe_n_a,
    input  logic              oe_n_b,
    input  logic              oe_hi,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] data_out,
    output logic              out_valid
);

    // Load the word at the rising edge of chip enable, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (evt == CE_RISE) begin
            data_q <= rd_word;
        end
    end

    // Drive only when every enable is in its active state
    always_comb begin
        out_valid = !oe_n_a && !oe_n_b && oe_hi;
        data_out  = out_valid ? data_q : '0;
    end

endmodule

// File: rtl/otp_rom_sync.sv
// Module otp_rom_sync
// Top level of the latched-address synchronous one-time-programmable ROM:
// an edge latch, a fuse array, and an output stage.
// Assumes all inputs are synchronous to clk and that reset blanks the array.
module otp_rom_sync
    import otp_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 8,
    parameter int ROW_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n_a,
    input  logic              oe_n_b,
    input  logic              oe_hi,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [$clog2(DATA_W)-1:0] prog_bit,
    output logic [DATA_W-1:0] data_out,
    output logic              out_valid
);

    localparam int COL_BITS = ADDR_W - ROW_BITS;
    localparam int BIT_W    = $clog2(DATA_W);
    localparam int ROWS     = 1 << ROW_BITS;
    localparam int COLS     = DATA_W << COL_BITS;

    ce_evt_t                 evt;
    logic                    ce_q;
    logic [ADDR_W-1:0]       addr_q;
    logic                    dec_en;
    logic [DATA_W-1:0]       rd_word;
    logic [ROWS-1:0]         row_sel;
    logic [ROWS*COLS-1:0]    fuse_flat;
    logic [DATA_W-1:0]       data_q;

    otp_edge_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .addr_in (addr),
        .evt     (evt),
        .ce_q    (ce_q),
        .addr_q  (addr_q),
        .dec_en  (dec_en)
    );

    otp_fuse_array #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .DATA_W   (DATA_W),
        .BIT_W    (BIT_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_addr (prog_addr),
        .prog_bit  (prog_bit),
        .dec_en    (dec_en),
        .rd_addr   (addr_q),
        .rd_word   (rd_word),
        .row_sel   (row_sel),
        .fuse_flat (fuse_flat)
    );

    otp_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .rd_word   (rd_word),
        .oe_n_a    (oe_n_a),
        .oe_n_b    (oe_n_b),
        .oe_hi     (oe_hi),
        .data_q    (data_q),
        .data_out  (data_out),
        .out_valid (out_valid)
    );

endmodule

// File: rtl/otp_rom_sync_chk.sv
// Module otp_rom_sync_chk
// Property checker for otp_rom_sync, attached by bind.
// Assumes rst_n is low at the first clock edge.
module otp_rom_sync_chk #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int ROWS   = 64,
    parameter int FUSES  = 4096
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ce_n,
    input logic                      ce_q,
    input logic [ADDR_W-1:0]         addr,
    input logic [ADDR_W-1:0]         addr_q,
    input logic                      dec_en,
    input logic [ROWS-1:0]           row_sel,
    input logic [DATA_W-1:0]         data_q,
    input logic [DATA_W-1:0]         data_out,
    input logic                      out_valid,
    input logic                      prog_en,
    input logic [ADDR_W-1:0]         prog_addr,
    input logic [$clog2(DATA_W)-1:0] prog_bit,
    input logic [FUSES-1:0]          fuse_flat
);

    // R2: a falling edge registers the address presented at that edge
    assert_addr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_q && !ce_n) |=> (addr_q == $past(addr)));

    // R2: without a falling edge the registered address does not move
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_q == ce_n) |=> $stable(addr_q));

    // R3: the output data register holds between enable edges
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_q == ce_n) |=> $stable(data_q));

    // R5: a program strobe leaves the selected fuse set
    assert_prog_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> fuse_flat[$past({prog_addr, prog_bit})]);

    // R6: no fuse ever returns to zero
    assert_fuse_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fuse_flat & $past(fuse_flat)) == $past(fuse_flat)));

    // R8: an undriven output carries no data
    assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (data_out == '0));

    // R10: exactly one row while the decoders are gated on
    assert_row_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> $onehot(row_sel));

    // R10: no row while the decoders are gated off
    assert_row_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |-> (row_sel == '0));

endmodule

bind otp_rom_sync otp_rom_sync_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ROWS   (ROWS),
    .FUSES  (ROWS*COLS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .ce_q      (ce_q),
    .addr      (addr),
    .addr_q    (addr_q),
    .dec_en    (dec_en),
    .row_sel   (row_sel),
    .data_q    (data_q),
    .data_out  (data_out),
    .out_valid (out_valid),
    .prog_en   (prog_en),
    .prog_addr (prog_addr),
    .prog_bit  (prog_bit),
    .fuse_flat (fuse_flat)
);

// File: tb/otp_rom_sync_tb.sv
`timescale 1ns/1ps
// Bench for otp_rom_sync: a vector table of program and read steps,
// then directed tests for reset, edge behaviour and output gating.
module otp_rom_sync_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic [8:0] addr = '0;
    logic       oe_n_a = 1'b0;
    logic       oe_n_b = 1'b0;
    logic       oe_hi = 1'b1;
    logic       prog_en = 1'b0;
    logic [8:0] prog_addr = '0;
    logic [2:0] prog_bit = '0;
    logic [7:0] data_out;
    logic       out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // 125 MHz clock
    always #4 clk = ~clk;

    otp_rom_sync u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .addr      (addr),
        .oe_n_a    (oe_n_a),
        .oe_n_b    (oe_n_b),
        .oe_hi     (oe_hi),
        .prog_en   (prog_en),
        .prog_addr (prog_addr),
        .prog_bit  (prog_bit),
        .data_out  (data_out),
        .out_valid (out_valid)
    );

    // Vector entry: {is_program, address, bit, expected word}
    localparam int NVEC = 13;
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 9'h000, 3'd0, 8'h00},
        {1'b1, 9'h000, 3'd7, 8'h00},
        {1'b0, 9'h000, 3'd0, 8'h81},
        {1'b0, 9'h001, 3'd0, 8'h00},
        {1'b1, 9'h1FF, 3'd3, 8'h00},
        {1'b0, 9'h1FF, 3'd0, 8'h08},
        {1'b1, 9'h008, 3'd1, 8'h00},
        {1'b0, 9'h008, 3'd0, 8'h02},
        {1'b0, 9'h000, 3'd0, 8'h81},
        {1'b1, 9'h1FF, 3'd3, 8'h00},
        {1'b0, 9'h1FF, 3'd0, 8'h08},
        {1'b1, 9'h040, 3'd6, 8'h00},
        {1'b0, 9'h040, 3'd0, 8'h40}
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Falling edge with address a, swap to junk, rising edge; ends where the word is visible
    task automatic do_read(input logic [8:0] a, input logic [8:0] junk);
        @(negedge clk); ce_n = 1'b0; addr = a;
        @(posedge clk);
        @(negedge clk); addr = junk; ce_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_prog(input logic [8:0] a, input logic [2:0] b);
        @(negedge clk); prog_en = 1'b1; prog_addr = a; prog_bit = b;
        @(posedge clk);
        @(negedge clk); prog_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; ce_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic set_oe(input logic a, input logic b, input logic h);
        oe_n_a = a; oe_n_b = b; oe_hi = h;
        #1;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state visible with output enabled
        @(negedge clk);
        chk(data_out, 8'h00, "R1 data after reset");
        chk({7'd0, out_valid}, 8'h01, "R7 valid after reset");
        do_read(9'h1FF, 9'h000);
        chk(data_out, 8'h00, "R1 blank array after reset");

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][20]) begin
                do_prog(VEC[i][19:11], VEC[i][10:8]);
            end else begin
                do_read(VEC[i][19:11], ~VEC[i][19:11]);
                chk(data_out, VEC[i][7:0], (VEC[i][7:0] == 8'h00) ? "R4 blank word" : "R5 R6 R10 programmed word");
            end
        end

        // R10: same row, other column group untouched
        do_read(9'h007, 9'h000);
        chk(data_out, 8'h00, "R10 other column group");

        // R2: address moved to a programmed word after the falling edge
        do_read(9'h001, 9'h000);
        chk(data_out, 8'h00, "R2 late address change ignored");

        // R3: programming while enable is high does not disturb the held word
        do_prog(9'h001, 3'd2);
        chk(data_out, 8'h00, "R3 word held while enable high");
        do_read(9'h001, 9'h1FF);
        chk(data_out, 8'h04, "R5 newly set bit");

        // R6: setting bit 0 of 0x000 again leaves 0x81
        do_prog(9'h000, 3'd0);
        do_read(9'h000, 9'h001);
        chk(data_out, 8'h81, "R6 repeat program");
        do_read(9'h001, 9'h000);

        // R7, R8: every enable combination
        for (int c = 0; c < 8; c++) begin
            logic ev;
            set_oe(c[0], c[1], c[2]);
            ev = !c[0] && !c[1] && c[2];
            chk({7'd0, out_valid}, {7'd0, ev}, "R7 enable combination");
            chk(data_out, ev ? 8'h04 : 8'h00, "R8 gated data");
        end

        // R9: read while disabled, then enable
        set_oe(1'b1, 1'b0, 1'b1);
        do_read(9'h000, 9'h001);
        chk(data_out, 8'h00, "R8 disabled during read");
        set_oe(1'b0, 1'b0, 1'b1);
        chk(data_out, 8'h81, "R9 word captured while disabled");
        set_oe(1'b0, 1'b0, 1'b0);
        set_oe(1'b0, 1'b0, 1'b1);
        chk(data_out, 8'h81, "R9 enable toggle keeps word");

        // R1: reset returns the array to blank
        do_reset();
        @(negedge clk);
        chk(data_out, 8'h00, "R1 data cleared");
        do_read(9'h000, 9'h1FF);
        chk(data_out, 8'h00, "R1 array cleared");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule